// File: doc/BRIEF.md
# Four-Phase Interpolating Gate-Time Counter

This block measures how long a gate input stays open with a resolution of a quarter of the reference clock period. It receives four clocks of the same frequency, each lagging the previous one by 90 degrees. Each clock drives its own counter. While the gate is high, every counter advances on the rising edges of its own clock. Because the four sets of edges interleave, the sum of the four counts grows by one every quarter period. The sum therefore behaves like a single counter running at four times the clock rate, and the ±1 count quantization shrinks to a quarter period.

The gate is re-timed into each clock domain before it controls that domain's counter. After the gate closes, a controller in the 0-degree domain waits until all four domains have seen the gate low. It then waits a fixed settle time, adds the frozen counts into a result two bits wider than one counter, and pulses a done strobe. An overflow flag is returned with each result. A user drives the gate high for the interval to be measured, drops it, and reads the sum and flag when done pulses.

Top module: `quad_phase_gate_counter`

## Requirements
- R1: While reset is asserted, and right after it is released, all four raw counts, the sum, the done strobe and the overflow flag read zero.
- R2: The count for phase i sits at bits [i*CNT_W +: CNT_W] of `phase_cnt`. It equals the number of rising edges of `clk_ph[i]` at which the two-stage re-timed gate was high, and it restarts from zero when a new measurement begins.
- R3: The sum is the zero-extended total of the four counts, CNT_W+2 bits wide. For a gate open D quarter-periods that starts between clock edges, the sum equals D.
- R4: `meas_done` is a single-cycle pulse in the `clk_ph[0]` domain. It is raised only after the gate is low in every domain plus SETTLE cycles, and it comes no later than 16 cycles of `clk_ph[0]` after the gate falls (default SETTLE).
- R5: `sum_cnt` changes only in the cycle in which `meas_done` is high, and holds between results.
- R6: `ovf` is reported with each result. It is 1 if any counter stepped past its all-ones value during that measurement, and 0 otherwise. A later clean measurement clears it.
- R7: After the gate falls, the raw counts hold their values until the gate rises again.
- R8: A gate rise after a done strobe starts a new measurement whose results do not depend on the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ph | input | 4 | Phase clocks at 0, 90, 180 and 270 degrees, bit i is phase i |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate | input | 1 | Measurement window, asynchronous to all clocks |
| phase_cnt | output | 4*CNT_W | Raw per-phase counts, phase i at [i*CNT_W +: CNT_W] |
| sum_cnt | output | CNT_W+2 | Combined count in quarter periods |
| meas_done | output | 1 | One-cycle result strobe, clk_ph[0] domain |
| ovf | output | 1 | Overflow flag returned with the result |

## Verification
A broken counter or synchronizer in any one domain shows up at once in that domain's raw count. The four expected counts differ for gate lengths that are not multiples of four, so swapped or misaligned phases are exposed. A broken controller shows up as a missing, repeated or late done strobe, or as a sum that changes between strobes, within the first result after the fault. An overflow fault appears on the first result whose gate crosses the counter limit, and the next short gate exposes a sticky flag that fails to clear.

// File: rtl/quad_phase_gate_counter.sv
module quad_phase_gate_counter #(
  parameter int CNT_W  = 20,
  parameter int SETTLE = 4,
  localparam int NPH   = 4,
  localparam int SUM_W = CNT_W + 2,
  localparam int SET_W = $clog2(SETTLE + 1)
) (
  input  logic [NPH-1:0]       clk_ph,
  input  logic                 rst_n,
  input  logic                 gate,
  output logic [NPH*CNT_W-1:0] phase_cnt,
  output logic [SUM_W-1:0]     sum_cnt,
  output logic                 meas_done,
  output logic                 ovf
);

  logic [NPH-1:0] low_v, wrap_v, lo_s1, lo_s2;
  logic           g0_rise;

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    logic             g_s1, g_s2, wrap;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk_ph[i] or negedge rst_n) begin
      if (!rst_n) begin
        g_s1 <= 1'b0;
        g_s2 <= 1'b0;
        cnt  <= '0;
        wrap <= 1'b0;
      end else begin
        g_s1 <= gate;
        g_s2 <= g_s1;
        if (g_s1 && !g_s2) begin
          cnt  <= '0;
          wrap <= 1'b0;
        end else if (g_s2) begin
          cnt <= cnt + 1'b1;
          if (&cnt) wrap <= 1'b1;
        end
      end
    end

    assign phase_cnt[i*CNT_W +: CNT_W] = cnt;
    assign low_v[i]  = ~g_s2;
    assign wrap_v[i] = wrap;

    if (i == 0) begin : g_r
      assign g0_rise = g_s1 & ~g_s2;
    end

    p_cnt_step_r2: assert property (@(posedge clk_ph[i]) disable iff (!rst_n)
      g_s2 |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    p_cnt_hold_r7: assert property (@(posedge clk_ph[i]) disable iff (!rst_n)
      (!g_s1 && !g_s2) |=> $stable(cnt));
    p_wrap_at_max_r6: assert property (@(posedge clk_ph[i]) disable iff (!rst_n)
      $rose(wrap) |-> (cnt == '0));
  end

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_HOLD} st_t;
  st_t             st;
  logic [SET_W-1:0] setl;

  always_ff @(posedge clk_ph[0] or negedge rst_n) begin
    if (!rst_n) begin
      lo_s1     <= '0;
      lo_s2     <= '0;
      st        <= S_IDLE;
      setl      <= '0;
      sum_cnt   <= '0;
      ovf       <= 1'b0;
      meas_done <= 1'b0;
    end else begin
      lo_s1     <= low_v;
      lo_s2     <= lo_s1;
      meas_done <= 1'b0;
      case (st)
        S_IDLE:  if (g0_rise) st <= S_RUN;
        S_RUN:   if (low_v[0]) st <= S_DRAIN;
        S_DRAIN: if (&lo_s2) begin
                   st   <= S_HOLD;
                   setl <= '0;
                 end
        S_HOLD:  if (setl == SET_W'(SETTLE - 1)) begin
                   sum_cnt   <= SUM_W'(phase_cnt[0*CNT_W +: CNT_W])
                              + SUM_W'(phase_cnt[1*CNT_W +: CNT_W])
                              + SUM_W'(phase_cnt[2*CNT_W +: CNT_W])
                              + SUM_W'(phase_cnt[3*CNT_W +: CNT_W]);
                   ovf       <= |wrap_v;
                   meas_done <= 1'b1;
                   st        <= S_IDLE;
                 end else begin
                   setl <= setl + 1'b1;
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_gate_low_r4: assert property (@(posedge clk_ph[0]) disable iff (!rst_n)
    meas_done |-> low_v[0]);
  p_done_pulse_r4: assert property (@(posedge clk_ph[0]) disable iff (!rst_n)
    meas_done |=> !meas_done);
  p_sum_hold_r5: assert property (@(posedge clk_ph[0]) disable iff (!rst_n)
    !$stable(sum_cnt) |-> meas_done);
  p_ovf_hold_r6: assert property (@(posedge clk_ph[0]) disable iff (!rst_n)
    !$stable(ovf) |-> meas_done);

endmodule

// File: tb/quad_phase_gate_counter_bench.sv
`timescale 1ns/100ps
module quad_phase_gate_counter_bench;
  localparam int CW = 8;
  localparam int SW = CW + 2;

  logic c0, c1, c2, c3, rst_n, gate;
  logic [3:0]      clk_ph;
  logic [4*CW-1:0] phase_cnt;
  logic [SW-1:0]   sum_cnt;
  logic            meas_done, ovf;
  int checks = 0, errors = 0;
  bit finished = 0;

  assign clk_ph = {c3, c2, c1, c0};

  initial begin c0 = 0; forever begin c0 = 1; #2; c0 = 0; #2; end end
  initial begin c1 = 0; #1; forever begin c1 = 1; #2; c1 = 0; #2; end end
  initial begin c2 = 0; #2; forever begin c2 = 1; #2; c2 = 0; #2; end end
  initial begin c3 = 0; #3; forever begin c3 = 1; #2; c3 = 0; #2; end end

  quad_phase_gate_counter #(.CNT_W(CW), .SETTLE(4)) u_quad_phase_gate_counter (
    .clk_ph(clk_ph), .rst_n(rst_n), .gate(gate), .phase_cnt(phase_cnt),
    .sum_cnt(sum_cnt), .meas_done(meas_done), .ovf(ovf));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int raw(int i);
    return int'(phase_cnt[i*CW +: CW]);
  endfunction

  task automatic t_reset();
    rst_n = 0; gate = 0;
    #21.5;
    chk("R1 sum in reset", sum_cnt, 0);
    chk("R1 done in reset", meas_done, 0);
    @(posedge c0); #0.5; rst_n = 1;
    @(posedge c0); #0.5;
    for (int i = 0; i < 4; i++) chk("R1 raw count", raw(i), 0);
    chk("R1 sum", sum_cnt, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 done", meas_done, 0);
  endtask

  task automatic t_measure(int d, bit exp_ovf);
    int e[4];
    int es = 0, n = 0;
    bit seen = 0;
    for (int i = 0; i < 4; i++) e[i] = 0;
    for (int o = 1; o <= d; o++) e[o % 4]++;
    for (int i = 0; i < 4; i++) es += e[i] % (1 << CW);
    @(posedge c0); #0.5; gate = 1;
    #(d); gate = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge c0); #0.5; n++;
      if (meas_done) begin seen = 1; break; end
    end
    chk("R4 done seen", seen, 1);
    checks++;
    if (n < 3 || n > 16) begin
      errors++;
      $display("FAIL R4 done latency actual=%0d expected=3..16", n);
    end
    chk("R3 sum", sum_cnt, es);
    chk("R6 ovf", ovf, exp_ovf);
    for (int i = 0; i < 4; i++) chk("R2 raw count", raw(i), e[i] % (1 << CW));
    @(posedge c0); #0.5;
    chk("R4 single pulse", meas_done, 0);
  endtask

  task automatic t_hold();
    int r[4];
    int s;
    for (int i = 0; i < 4; i++) r[i] = raw(i);
    s = sum_cnt;
    repeat (20) @(posedge c0);
    #0.5;
    for (int i = 0; i < 4; i++) chk("R7 raw hold", raw(i), r[i]);
    chk("R5 sum hold", sum_cnt, s);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_measure(13, 0);
    t_measure(16, 0);
    t_measure(37, 0);   // R8 second result independent of first
    t_hold();
    t_measure(1024, 1); // R6 each counter wraps
    t_measure(20, 0);   // R6 flag cleared
    t_measure(1020, 0); // R6 boundary at all-ones
    t_hold();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule